// File: doc/BRIEF.md
# Wait-Freeze Microcode Bus Sequencer

This block runs short user-written programs that generate bus waveforms. A program is a run of words in a 64-entry control store, and the block executes one word per clock. Each word sets the chip-select and four general-purpose strobe lines for that clock. Each word also carries control flags:

- wait-enable
- transfer-acknowledge
- burst-address step
- late data-sample
- end-of-program

Software loads the control store through a plain write port. A start request names the first word and the initial burst address.

An external wait line can stall the program on any word that has wait-enable set. While stalled, that word's outputs repeat each clock. By default the wait line passes through a two-flop synchronizer, so it may change at any time. When both the mode-enable input and the strobe-mode input are high, the block runs in synchronous mode. In that mode a word that has both wait-enable and acknowledge set reads the raw wait line at the clock edge. It raises the acknowledge in the same cycle that wait is seen low, and the data-transfer strobe follows one clock later. Words that break the programming rules raise a sticky configuration error.

Top module: `ubs_top`

## Requirements
- R1: After reset the block is idle: `cs_n` is high, `strobe` is zero, and `xfer_ack`, `data_xfer`, `late_smp`, `busy` and `cfg_err` are low.
- R2: When idle, a `start` pulse loads `start_idx` as the word pointer and `start_baddr` as the burst address. Each following clock executes one word. `cs_n`, `strobe` and `late_smp` follow that word's bits. After a word with the end-of-program flag, `cs_n` returns high and `busy` falls.
- R3: A word with wait-enable is frozen while the effective wait is high. It repeats its outputs, and the pointer does not advance. In the default mode the effective wait is `wait_in` through two flops. If `wait_in` falls in the cycle before edge k+1, a three-word program whose middle word is frozen holds `cs_n` low for k+4 cycles.
- R4: A word with the step flag advances `burst_addr` by exactly one, however many cycles it stays frozen.
- R5: `xfer_ack` is high in each cycle where the current word has the acknowledge flag and is not frozen. `data_xfer` is high exactly one clock after each `xfer_ack` cycle.
- R6: In synchronous mode, a word with both wait-enable and acknowledge reads `wait_in` without synchronization. `xfer_ack` rises in the same cycle that `wait_in` is low.
- R7: Synchronous mode needs both `sync_en` and `strobe_mode` high. With either one low, the combined word uses the synchronized wait and ordinary timing.
- R8: `cfg_err` is set by any of these executed words:
  - a word with wait-enable plus acknowledge outside synchronous mode;
  - such a word with the late-sample flag also set;
  - a word with any reserved bit set.
  
  `cfg_err` stays set until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored. It changes neither the program flow nor `burst_addr`.
- R10: The word layout is: bits 3:0 strobes, bit 4 chip-select active, bit 5 wait-enable, bit 6 acknowledge, bit 7 burst step, bit 8 late sample, bit 9 end-of-program, bits 31:10 reserved.
- R11: A clock with `ram_we` high writes `ram_wdata` into word `ram_waddr`. A later program that runs from that word follows the written contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ram_we | input | 1 | Control store write strobe |
| ram_waddr | input | 6 | Control store write index |
| ram_wdata | input | 32 | Control store write data |
| start | input | 1 | Start request, honoured only when idle |
| start_idx | input | 6 | First word of the program |
| start_baddr | input | 8 | Initial burst address |
| wait_in | input | 1 | External wait, active high |
| sync_en | input | 1 | Synchronous mode enable |
| strobe_mode | input | 1 | Strobe-mode qualifier for synchronous mode |
| cs_n | output | 1 | Chip-select, active low |
| strobe | output | 4 | General-purpose strobes |
| late_smp | output | 1 | Late data-sample marker of current word |
| xfer_ack | output | 1 | Internal transfer acknowledge |
| data_xfer | output | 1 | Data transfer, one clock after acknowledge |
| burst_addr | output | 8 | Burst address |
| busy | output | 1 | Program running |
| cfg_err | output | 1 | Sticky programming-rule violation |

## Verification
The hardest situation to reach is the early acknowledge. The combined word has to be executing while `wait_in` is still high, and `wait_in` then has to fall part-way through a clock, with no synchronizer delay involved. The bench gets there by holding wait high before the start, so the combined word freezes on arrival. It then drops wait on a chosen falling edge and samples `xfer_ack` just after, within that same cycle. The same freeze is repeated with a single qualifier removed, and the bench checks that the acknowledge then moves two cycles later.

// File: rtl/ubs_pkg.sv
package ubs_pkg;

    localparam int STRB_W = 4;
    localparam int WORD_W = 32;
    localparam int FLAG_W = 6;
    localparam int RSVD_W = WORD_W - FLAG_W - STRB_W;

    // Control word layout, LSB first: strobes, cs, wait-en, ack, step, late, last
    typedef struct packed {
        logic [RSVD_W-1:0] rsvd;
        logic              last;
        logic              late;
        logic              step;
        logic              ack;
        logic              wen;
        logic              cs;
        logic [STRB_W-1:0] strb;
    } uword_t;

endpackage

// File: rtl/ubs_ctrl_ram.sv
module ubs_ctrl_ram #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Combinational read so the word executes in the cycle its index is held
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/ubs_wait_path.sv
module ubs_wait_path #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_in,
    input  logic direct,
    output logic wait_eff
);
    logic synced;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] sync_d, sync_q;

            always_comb begin
                sync_d[0] = wait_in;
                for (int i = 1; i < SYNC_STAGES; i++) begin
                    sync_d[i] = sync_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q <= '0;
                end else begin
                    sync_q <= sync_d;
                end
            end

            assign synced = sync_q[SYNC_STAGES-1];
        end else begin : g_nosync
            assign synced = wait_in;
        end
    endgenerate

    // Direct path skips the synchronizer for the early-acknowledge word
    assign wait_eff = direct ? wait_in : synced;

endmodule

// File: rtl/ubs_burst_ctr.sv
module ubs_burst_ctr #(
    parameter int BA_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BA_W-1:0] load_val,
    input  logic            step,
    output logic [BA_W-1:0] addr
);
    logic [BA_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = load_val;
        end else if (step) begin
            addr_d = addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/ubs_top.sv
module ubs_top
    import ubs_pkg::*;
#(
    parameter int AW          = 6,
    parameter int BA_W        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ram_we,
    input  logic [AW-1:0]     ram_waddr,
    input  logic [WORD_W-1:0] ram_wdata,
    input  logic              start,
    input  logic [AW-1:0]     start_idx,
    input  logic [BA_W-1:0]   start_baddr,
    input  logic              wait_in,
    input  logic              sync_en,
    input  logic              strobe_mode,
    output logic              cs_n,
    output logic [STRB_W-1:0] strobe,
    output logic              late_smp,
    output logic              xfer_ack,
    output logic              data_xfer,
    output logic [BA_W-1:0]   burst_addr,
    output logic              busy,
    output logic              cfg_err
);

    typedef struct packed {
        logic          run;
        logic [AW-1:0] pc;
        logic          stepped;
        logic          err;
        logic          dx;
    } seq_t;

    seq_t st_d, st_q;

    logic [WORD_W-1:0] rd_word;
    uword_t            cur;
    logic              sync_ok;
    logic              direct_sel;
    logic              wait_eff;
    logic              frozen;
    logic              ack_w;
    logic              launch;
    logic              do_step;
    logic              bad_word;

    ubs_ctrl_ram #(.AW(AW), .DW(WORD_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (st_q.pc),
        .rdata (rd_word)
    );

    assign cur        = uword_t'(rd_word);
    assign sync_ok    = sync_en & strobe_mode;
    assign direct_sel = sync_ok & cur.wen & cur.ack;

    ubs_wait_path #(.SYNC_STAGES(SYNC_STAGES)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .wait_in  (wait_in),
        .direct   (direct_sel),
        .wait_eff (wait_eff)
    );

    assign frozen   = st_q.run & cur.wen & wait_eff;
    assign ack_w    = st_q.run & cur.ack & ~frozen;
    assign launch   = ~st_q.run & start;
    assign do_step  = st_q.run & cur.step & ~st_q.stepped;
    assign bad_word = (cur.wen & cur.ack & (~sync_ok | cur.late)) | (|cur.rsvd);

    ubs_burst_ctr #(.BA_W(BA_W)) u_bctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (start_baddr),
        .step     (do_step),
        .addr     (burst_addr)
    );

    always_comb begin
        st_d    = st_q;
        st_d.dx = ack_w;
        if (!st_q.run) begin
            st_d.stepped = 1'b0;
            if (start) begin
                st_d.run = 1'b1;
                st_d.pc  = start_idx;
                st_d.err = 1'b0;
            end
        end else begin
            if (bad_word) begin
                st_d.err = 1'b1;
            end
            if (frozen) begin
                // Remember a step already taken so a long freeze steps once
                st_d.stepped = st_q.stepped | cur.step;
            end else begin
                st_d.stepped = 1'b0;
                if (cur.last) begin
                    st_d.run = 1'b0;
                end else begin
                    st_d.pc = st_q.pc + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_n      = ~(st_q.run & cur.cs);
    assign strobe    = st_q.run ? cur.strb : '0;
    assign late_smp  = st_q.run & cur.late;
    assign xfer_ack  = ack_w;
    assign data_xfer = st_q.dx;
    assign busy      = st_q.run;
    assign cfg_err   = st_q.err;

endmodule

// File: rtl/ubs_checker.sv
module ubs_checker #(
    parameter int AW   = 6,
    parameter int BA_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            cs_n,
    input logic            xfer_ack,
    input logic            data_xfer,
    input logic [BA_W-1:0] burst_addr,
    input logic            cfg_err,
    input logic [AW-1:0]   pc,
    input logic            frozen
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && !xfer_ack));

    assert_freeze_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> ($stable(pc) && busy));

    assert_addr_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (burst_addr == $past(burst_addr) || burst_addr == $past(burst_addr) + 1'b1));

    assert_xfer_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ack |=> data_xfer);

    assert_no_stray_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_ack |=> !data_xfer);

    assert_no_ack_when_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !xfer_ack);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_err) |=> cfg_err);

endmodule

bind ubs_top ubs_checker #(.AW(AW), .BA_W(BA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cs_n       (cs_n),
    .xfer_ack   (xfer_ack),
    .data_xfer  (data_xfer),
    .burst_addr (burst_addr),
    .cfg_err    (cfg_err),
    .pc         (st_q.pc),
    .frozen     (frozen)
);

// File: tb/ubs_top_bench.sv
module ubs_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ram_we = 1'b0;
    logic [5:0]  ram_waddr = '0;
    logic [31:0] ram_wdata = '0;
    logic        start = 1'b0;
    logic [5:0]  start_idx = '0;
    logic [7:0]  start_baddr = '0;
    logic        wait_in = 1'b0;
    logic        sync_en = 1'b0;
    logic        strobe_mode = 1'b0;
    logic        cs_n;
    logic [3:0]  strobe;
    logic        late_smp;
    logic        xfer_ack;
    logic        data_xfer;
    logic [7:0]  burst_addr;
    logic        busy;
    logic        cfg_err;

    int checks = 0;
    int errs   = 0;
    bit fin    = 1'b0;

    int m_cs, m_g, m_ack_at, m_dx_at, m_ack_cnt, m_late_at;

    always #2 clk = ~clk;

    ubs_top u_ubs_top (
        .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_waddr(ram_waddr),
        .ram_wdata(ram_wdata), .start(start), .start_idx(start_idx),
        .start_baddr(start_baddr), .wait_in(wait_in), .sync_en(sync_en),
        .strobe_mode(strobe_mode), .cs_n(cs_n), .strobe(strobe),
        .late_smp(late_smp), .xfer_ack(xfer_ack), .data_xfer(data_xfer),
        .burst_addr(burst_addr), .busy(busy), .cfg_err(cfg_err)
    );

    // Word encoding from R10
    function automatic logic [31:0] mk(input logic [3:0] s, input bit cs, input bit wen,
                                       input bit ack, input bit stp, input bit late,
                                       input bit last);
        return {22'b0, last, late, stp, ack, wen, cs, s};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [31:0] w);
        @(negedge clk);
        ram_we = 1'b1; ram_waddr = a[5:0]; ram_wdata = w;
        @(negedge clk);
        ram_we = 1'b0;
    endtask

    task automatic settle_wait(input bit v);
        wait_in = v;
        repeat (4) @(negedge clk);
    endtask

    // Launch program at idx, drop wait on falling edge n_drop, optional start pulse at n_intr
    task automatic run(input int idx, input int baddr, input int drop, input logic [3:0] gm,
                       input int intr);
        m_cs = 0; m_g = 0; m_ack_at = -1; m_dx_at = -1; m_ack_cnt = 0; m_late_at = -1;
        @(negedge clk);
        start = 1'b1; start_idx = idx[5:0]; start_baddr = baddr[7:0];
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            if (i == 0) start = 1'b0;
            if (i == intr) begin start = 1'b1; start_idx = 6'd0; start_baddr = 8'h80; end
            if (i == intr + 1) start = 1'b0;
            if (i == drop) wait_in = 1'b0;
            #1;
            if (!cs_n) m_cs++;
            if (!cs_n && strobe == gm) m_g++;
            if (xfer_ack) begin m_ack_cnt++; if (m_ack_at < 0) m_ack_at = i; end
            if (data_xfer && m_dx_at < 0) m_dx_at = i;
            if (late_smp && m_late_at < 0) m_late_at = i;
        end
    endtask

    task automatic t_reset();
        chk("R1", "cs_n", cs_n, 1);
        chk("R1", "strobe", strobe, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "ack|xfer|late", {xfer_ack, data_xfer, late_smp}, 0);
        chk("R1", "cfg_err", cfg_err, 0);
    endtask

    task automatic t_basic();
        settle_wait(1'b0);
        run(24, 8'h05, -1, 4'h3, -1);
        chk("R2", "cs cycles", m_cs, 3);
        chk("R2", "middle word strobes", m_g, 1);
        chk("R2", "late sample cycle", m_late_at, 1);
        chk("R5", "ack cycle", m_ack_at, 2);
        chk("R5", "xfer cycle", m_dx_at, 3);
        chk("R2", "busy after last", busy, 0);
        chk("R11", "written program ran, strobe idle", strobe, 0);
    endtask

    task automatic t_async(input int k);
        settle_wait(1'b1);
        run(0, 0, k, 4'h2, -1);
        chk("R3", $sformatf("cs cycles k=%0d", k), m_cs, k + 4);
        chk("R3", $sformatf("frozen word repeats k=%0d", k), m_g, k + 2);
        chk("R5", $sformatf("ack cycle k=%0d", k), m_ack_at, k + 3);
        chk("R5", $sformatf("xfer cycle k=%0d", k), m_dx_at, k + 4);
        chk("R5", "single ack", m_ack_cnt, 1);
    endtask

    task automatic t_burst();
        settle_wait(1'b1);
        run(8, 8'h10, 4, 4'h2, 2);
        chk("R4", "addr after frozen step words", burst_addr, 8'h13);
        chk("R9", "start while busy ignored, cs cycles", m_cs, 8);
        settle_wait(1'b0);
        run(8, 8'h20, -1, 4'h2, -1);
        chk("R4", "addr without freeze", burst_addr, 8'h23);
    endtask

    task automatic t_sync(input int k);
        sync_en = 1'b1; strobe_mode = 1'b1;
        settle_wait(1'b1);
        run(16, 0, k, 4'h2, -1);
        chk("R6", $sformatf("early ack cycle k=%0d", k), m_ack_at, k);
        chk("R6", $sformatf("xfer one clock later k=%0d", k), m_dx_at, k + 1);
        chk("R6", $sformatf("cs cycles k=%0d", k), m_cs, k + 2);
        chk("R8", "no error in legal sync use", cfg_err, 0);
    endtask

    task automatic t_gate();
        sync_en = 1'b1; strobe_mode = 1'b0;
        settle_wait(1'b1);
        run(16, 0, 3, 4'h2, -1);
        chk("R7", "ack cycle with qualifier low", m_ack_at, 5);
        chk("R7", "cs cycles with qualifier low", m_cs, 7);
        chk("R8", "combined word outside sync mode", cfg_err, 1);
    endtask

    task automatic t_late();
        sync_en = 1'b1; strobe_mode = 1'b1;
        settle_wait(1'b1);
        run(32, 0, 2, 4'h2, -1);
        chk("R8", "late bit in combined word", cfg_err, 1);
        settle_wait(1'b1);
        run(16, 0, 2, 4'h2, -1);
        chk("R8", "error cleared by next start", cfg_err, 0);
        sync_en = 1'b0; strobe_mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // async freeze program
        put(0,  mk(4'h1, 1, 0, 0, 0, 0, 0));
        put(1,  mk(4'h2, 1, 1, 0, 0, 0, 0));
        put(2,  mk(4'h4, 1, 0, 1, 0, 0, 1));
        // burst step program
        put(8,  mk(4'h1, 1, 0, 0, 1, 0, 0));
        put(9,  mk(4'h2, 1, 1, 0, 1, 0, 0));
        put(10, mk(4'h4, 1, 0, 1, 1, 0, 1));
        // combined wait-enable + ack program
        put(16, mk(4'h1, 1, 0, 0, 0, 0, 0));
        put(17, mk(4'h2, 1, 1, 1, 0, 0, 0));
        put(18, mk(4'h4, 1, 0, 0, 0, 0, 1));
        // plain program
        put(24, mk(4'h1, 1, 0, 0, 0, 0, 0));
        put(25, mk(4'h3, 1, 0, 0, 0, 1, 0));
        put(26, mk(4'h7, 1, 0, 1, 0, 0, 1));
        // combined word with late sample (illegal)
        put(32, mk(4'h1, 1, 0, 0, 0, 0, 0));
        put(33, mk(4'h2, 1, 1, 1, 0, 1, 0));
        put(34, mk(4'h4, 1, 0, 0, 0, 0, 1));
        t_basic();
        t_async(1);
        t_async(3);
        t_async(6);
        t_burst();
        t_sync(2);
        t_sync(5);
        t_gate();
        t_late();
        fin = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin) begin
            checks++;
            errs++;
            $display("FAIL watchdog all-requirements actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule